// File: doc/BRIEF.md
# Burst Capture Controller for a Pipelined Sample Source

This block gathers one burst of samples from a pipelined 8-bit converter into an on-chip first-in first-out store, and then lets a slow host drain it one word per strobe. The common sample tick is gated by two host control bits. One enables the converter and one enables storage. The storage gate opens only after a programmable number of converter ticks, so the words that are still in the converter pipeline are thrown away and never stored.

When the store holds as many words as it has entries, it refuses further writes and its active-low full flag drops. The falling edge of that flag sets a sticky interrupt. The host then clears both gates and reads the buffer out through a single-strobe port. Before each burst the host asks for a clear pulse. This pulse is driven out of the block, empties the store and withdraws the interrupt. The host and the sample side share one clock. Sample ticks and read strobes are single-cycle pulses.

Top module: `burst_capture_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge): full_n_o = 1, empty_n_o = 0, irq_o = 0, fifo_rst_n_o = 1, rd_data_o = 0, and the store holds no words.
- R2: adc_enc_o is high in exactly those cycles where smp_tick_i = 1 and conv_gate_i = 1 (combinational gate).
- R3: Converter ticks are numbered from 0 starting at the first tick after conv_gate_i goes high, and conv_gate_i low resets the numbering. A tick with number below skew_i is never stored. With store_gate_i high, every later tick stores smp_data_i, in arrival order.
- R4: A tick in a cycle with store_gate_i = 0 is not stored, even when the skew has elapsed. Toggling store_gate_i does not restart the tick numbering.
- R5: Once 2^ADDR_W words are held, full_n_o is 0 and further ticks are ignored. The stored contents do not change.
- R6: irq_o goes to 1 on the clock edge that follows the cycle in which full_n_o fell. It then stays at 1 until irq_ack_i is high at an edge or a clear pulse occurs.
- R7: When the store is non-empty and rd_n_i is low at an edge, rd_data_o shows the oldest word after that edge. empty_n_o is 0 exactly when no words are held.
- R8: A read strobe while the store is empty leaves rd_data_o unchanged and does not move the read position. The next word written is the next word read.
- R9: A clr_req_i pulse at an edge drives fifo_rst_n_o low for exactly CLR_LEN cycles starting after that edge. During the pulse both positions are cleared (empty_n_o = 0, full_n_o = 1) and irq_o returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for sample and host sides |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_tick_i | input | 1 | One-cycle sample clock tick |
| smp_data_i | input | DATA_W | Converter output word for this tick |
| conv_gate_i | input | 1 | Host enable for the converter tick |
| store_gate_i | input | 1 | Host enable for the storage tick |
| skew_i | input | SKEW_W | Number of initial converter ticks to discard |
| adc_enc_o | output | 1 | Gated tick sent to the converter |
| clr_req_i | input | 1 | One-cycle request for a clear pulse |
| fifo_rst_n_o | output | 1 | Active-low clear pulse, CLR_LEN cycles |
| rd_n_i | input | 1 | Active-low one-cycle read strobe |
| rd_data_o | output | DATA_W | Word returned by the last successful read |
| full_n_o | output | 1 | Low when the store is full |
| empty_n_o | output | 1 | Low when the store is empty |
| irq_o | output | 1 | Sticky burst-complete interrupt |
| irq_ack_i | input | 1 | Host acknowledge, clears irq_o |

## Verification
The assertions take for granted that skew_i is held constant while conv_gate_i is high. They also take for granted that smp_tick_i, rd_n_i, clr_req_i and irq_ack_i are single-cycle pulses that are never driven while rst_n is low. The stimulus changes skew_i only while both gates are closed, and drives every strobe for one cycle from the falling clock edge. It also never reads in the same cycle as a storing tick, so the model of occupancy stays exact. Bursts run with skew values 4, 0 and 7. Data patterns differ per burst, so a misplaced or dropped word shows up in the scoreboard.

// File: rtl/bcap_pkg.sv
// Package: shared defaults for the burst capture controller.
// Assumes: every module below takes its widths from these values
// unless its instantiation overrides them.
package bcap_pkg;
    parameter int unsigned DEF_DATA_W  = 8;   // converter word width
    parameter int unsigned DEF_ADDR_W  = 11;  // store holds 2^ADDR_W words
    parameter int unsigned DEF_SKEW_W  = 4;   // width of the discard count
    parameter int unsigned DEF_CLR_LEN = 2;   // clear pulse length in cycles
endpackage

// File: rtl/bcap_pointer_clear.sv
// Module: bcap_pointer_clear
// Turns a one-cycle request into an active-low pulse CLR_LEN cycles long.
// Assumes: CLR_LEN >= 1. A request that arrives while a pulse is running
// is ignored.
module bcap_pointer_clear #(
    parameter int unsigned CLR_LEN = bcap_pkg::DEF_CLR_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic pulse_n_o
);
    localparam int unsigned CNT_W = $clog2(CLR_LEN + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CLR_LEN);

    logic [CNT_W-1:0] remain_q;

    // Load the countdown on a request and run it down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end else if (req_i) begin
            remain_q <= LOAD;
        end
    end

    assign pulse_n_o = (remain_q == '0);

    // R9: an idle request always starts the pulse on the next cycle.
    assert_pulse_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && pulse_n_o) |=> !pulse_n_o);
endmodule

// File: rtl/bcap_capture_seq.sv
// Module: bcap_capture_seq
// Gates the sample tick for the converter and for storage. It counts the
// converter ticks since the converter gate opened and keeps the storage
// tick closed until skew_i of them have passed.
// Assumes: skew_i is held constant while conv_gate_i is high.
module bcap_capture_seq #(
    parameter int unsigned SKEW_W = bcap_pkg::DEF_SKEW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_tick_i,
    input  logic              conv_gate_i,
    input  logic              store_gate_i,
    input  logic [SKEW_W-1:0] skew_i,
    output logic              adc_enc_o,
    output logic              wr_stb_o
);
    logic [SKEW_W-1:0] skew_cnt_q;
    logic              skew_done;

    // Count converter ticks up to skew_i; a closed converter gate restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            skew_cnt_q <= '0;
        end else if (!conv_gate_i) begin
            skew_cnt_q <= '0;
        end else if (smp_tick_i && (skew_cnt_q < skew_i)) begin
            skew_cnt_q <= skew_cnt_q + 1'b1;
        end
    end

    // Converter tick and qualified storage tick.
    always_comb begin
        skew_done = (skew_cnt_q >= skew_i);
        adc_enc_o = smp_tick_i & conv_gate_i;
        wr_stb_o  = adc_enc_o & store_gate_i & skew_done;
    end

    // R3: a closed converter gate restarts the discard count.
    assert_gate_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_gate_i |=> (skew_cnt_q == '0));
    // R3: with a non-zero skew no tick can be stored in the first gated cycle.
    assert_no_early_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_o && (skew_i != '0)) |-> $past(conv_gate_i));
endmodule

// File: rtl/bcap_sample_fifo.sv
// Module: bcap_sample_fifo
// Single-clock store of 2^ADDR_W words. A word is written while wr_en1_n_i
// is low, wr_en2_i is high and the store is not full. The oldest word is
// read on an active read request while the store is not empty. A low clr_n_i
// empties the store and takes priority over reads and writes.
// Assumes: rd_req_i is a one-cycle pulse; read data stays as it was when
// nothing is read.
module bcap_sample_fifo #(
    parameter int unsigned DATA_W = bcap_pkg::DEF_DATA_W,
    parameter int unsigned ADDR_W = bcap_pkg::DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n_i,
    input  logic              wr_en1_n_i,
    input  logic              wr_en2_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_req_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              full_o,
    output logic              empty_o
);
    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W:0] FULL_CNT = {1'b1, {ADDR_W{1'b0}}};

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [ADDR_W-1:0] wptr_q;
    logic [ADDR_W-1:0] rptr_q;
    logic [ADDR_W:0]   fill_q;
    logic              wr_ok;
    logic              rd_ok;

    // Flags and accepted operations.
    always_comb begin
        full_o  = (fill_q == FULL_CNT);
        empty_o = (fill_q == '0);
        wr_ok   = !wr_en1_n_i && wr_en2_i && !full_o && clr_n_i;
        rd_ok   = rd_req_i && !empty_o && clr_n_i;
    end

    // Storage array write.
    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem_q[wptr_q] <= wr_data_i;
        end
    end

    // Pointer and fill level update; clearing wins over everything.
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_n_i) begin
            wptr_q <= '0;
            rptr_q <= '0;
            fill_q <= '0;
        end else begin
            if (wr_ok) begin
                wptr_q <= wptr_q + 1'b1;
            end
            if (rd_ok) begin
                rptr_q <= rptr_q + 1'b1;
            end
            case ({wr_ok, rd_ok})
                2'b10:   fill_q <= fill_q + 1'b1;
                2'b01:   fill_q <= fill_q - 1'b1;
                default: fill_q <= fill_q;
            endcase
        end
    end

    // Read data register, held when no word is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_o <= '0;
        end else if (rd_ok) begin
            rd_data_o <= mem_q[rptr_q];
        end
    end

    // R5: a full store never advances its write position.
    assert_full_blocks_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && clr_n_i) |=> (wptr_q == $past(wptr_q)));
    // R8: reading an empty store keeps the returned word and the read position.
    assert_empty_read_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && rd_req_i) |=> ($stable(rd_data_o) && $stable(rptr_q)));
    // R9: a clear leaves the store empty and not full.
    assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n_i |=> (empty_o && !full_o));
endmodule

// File: rtl/bcap_irq_latch.sv
// Module: bcap_irq_latch
// Sets a sticky interrupt on the falling edge of the active-low full flag.
// Assumes: acknowledge and clear both withdraw the interrupt, and
// acknowledge wins over a same-cycle edge.
module bcap_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic full_n_i,
    input  logic ack_i,
    input  logic clr_n_i,
    output logic irq_o
);
    logic full_n_q;

    // Remember the previous full flag for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_n_q <= 1'b1;
        end else begin
            full_n_q <= full_n_i;
        end
    end

    // Sticky interrupt flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else if (ack_i || !clr_n_i) begin
            irq_o <= 1'b0;
        end else if (full_n_q && !full_n_i) begin
            irq_o <= 1'b1;
        end
    end

    // R6: the full flag falling raises the interrupt one cycle later.
    assert_irq_on_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(full_n_i) && !ack_i && clr_n_i) |=> irq_o);
    // R6: the interrupt holds until acknowledged or cleared.
    assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ack_i && clr_n_i) |=> irq_o);
endmodule

// File: rtl/burst_capture_ctrl.sv
// Module: burst_capture_ctrl (top)
// Burst capture controller: gates the converter and storage ticks, keeps the
// samples in a single-clock store, raises a sticky interrupt when the store
// fills, serves host reads by strobe and issues the clear pulse before a burst.
// Assumes: one clock for both sides; ticks and strobes last one cycle.
module burst_capture_ctrl #(
    parameter int unsigned DATA_W  = bcap_pkg::DEF_DATA_W,
    parameter int unsigned ADDR_W  = bcap_pkg::DEF_ADDR_W,
    parameter int unsigned SKEW_W  = bcap_pkg::DEF_SKEW_W,
    parameter int unsigned CLR_LEN = bcap_pkg::DEF_CLR_LEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_tick_i,
    input  logic [DATA_W-1:0] smp_data_i,
    input  logic              conv_gate_i,
    input  logic              store_gate_i,
    input  logic [SKEW_W-1:0] skew_i,
    output logic              adc_enc_o,
    input  logic              clr_req_i,
    output logic              fifo_rst_n_o,
    input  logic              rd_n_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              full_n_o,
    output logic              empty_n_o,
    output logic              irq_o,
    input  logic              irq_ack_i
);
    logic cap_stb;
    logic clr_n;
    logic full;
    logic empty;

    // Clear pulse generator.
    bcap_pointer_clear #(.CLR_LEN(CLR_LEN)) u_clear (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (clr_req_i),
        .pulse_n_o (clr_n)
    );

    // Tick gating and pipeline discard.
    bcap_capture_seq #(.SKEW_W(SKEW_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .smp_tick_i   (smp_tick_i),
        .conv_gate_i  (conv_gate_i),
        .store_gate_i (store_gate_i),
        .skew_i       (skew_i),
        .adc_enc_o    (adc_enc_o),
        .wr_stb_o     (cap_stb)
    );

    // Sample store; the second write enable blocks writes during a clear.
    bcap_sample_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_n_i    (clr_n),
        .wr_en1_n_i (!cap_stb),
        .wr_en2_i   (clr_n),
        .wr_data_i  (smp_data_i),
        .rd_req_i   (!rd_n_i),
        .rd_data_o  (rd_data_o),
        .full_o     (full),
        .empty_o    (empty)
    );

    // Active-low flags seen by the host.
    always_comb begin
        full_n_o     = !full;
        empty_n_o    = !empty;
        fifo_rst_n_o = clr_n;
    end

    // Burst-complete interrupt.
    bcap_irq_latch u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .full_n_i (full_n_o),
        .ack_i    (irq_ack_i),
        .clr_n_i  (clr_n),
        .irq_o    (irq_o)
    );
endmodule

// File: tb/burst_capture_ctrl_tb_top.sv
// Scoreboard bench: the driver predicts stored words into a queue and a
// monitor pops them as read data appears.
module burst_capture_ctrl_tb_top;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 5;
    localparam int SKEW_W  = 4;
    localparam int CLR_LEN = 2;
    localparam int DEPTH   = 1 << ADDR_W;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              smp_tick_i = 1'b0;
    logic [DATA_W-1:0] smp_data_i = '0;
    logic              conv_gate_i = 1'b0;
    logic              store_gate_i = 1'b0;
    logic [SKEW_W-1:0] skew_i = 4'd4;
    logic              adc_enc_o;
    logic              clr_req_i = 1'b0;
    logic              fifo_rst_n_o;
    logic              rd_n_i = 1'b1;
    logic [DATA_W-1:0] rd_data_o;
    logic              full_n_o;
    logic              empty_n_o;
    logic              irq_o;
    logic              irq_ack_i = 1'b0;

    burst_capture_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SKEW_W(SKEW_W),
                         .CLR_LEN(CLR_LEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_tick_i(smp_tick_i), .smp_data_i(smp_data_i),
        .conv_gate_i(conv_gate_i), .store_gate_i(store_gate_i), .skew_i(skew_i),
        .adc_enc_o(adc_enc_o), .clr_req_i(clr_req_i), .fifo_rst_n_o(fifo_rst_n_o),
        .rd_n_i(rd_n_i), .rd_data_o(rd_data_o), .full_n_o(full_n_o),
        .empty_n_o(empty_n_o), .irq_o(irq_o), .irq_ack_i(irq_ack_i)
    );

    int checks = 0;
    int fails = 0;
    int cyc_cnt = 0;
    int model_cnt = 0;
    int gate_n = 0;
    logic [DATA_W-1:0] exp_q[$];
    logic [DATA_W-1:0] last_rd = '0;
    string rd_tag = "R7";
    bit prev_full_n = 1'b1;
    bit expect_irq = 1'b0;

    function automatic void check(input bit ok, input string req, input string what,
                                  input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 100000) begin
            fails++;
            $display("FAIL watchdog cycles actual=%0d expected=%0d", cyc_cnt, 100000);
            summary();
            $finish;
        end
    end

    // Driver: one cycle of tick/read stimulus plus the storage prediction.
    task automatic step(input bit tk, input logic [DATA_W-1:0] d, input bit rd);
        @(negedge clk);
        smp_tick_i = tk;
        smp_data_i = d;
        rd_n_i     = !rd;
        #1;
        check(adc_enc_o == (tk & conv_gate_i), "R2", "adc_enc_o",
              int'(adc_enc_o), int'(tk & conv_gate_i));
        if (tk && conv_gate_i) begin
            if (store_gate_i && gate_n >= int'(skew_i) && model_cnt < DEPTH) begin
                exp_q.push_back(d);
                model_cnt++;
            end
            gate_n++;
        end
        if (rd && model_cnt > 0) model_cnt--;
    endtask

    task automatic gates(input bit c, input bit s);
        @(negedge clk);
        smp_tick_i   = 1'b0;
        rd_n_i       = 1'b1;
        conv_gate_i  = c;
        store_gate_i = s;
        if (!c) gate_n = 0;
    endtask

    // Clear pulse: checks the pulse length and flushes the model (R9).
    task automatic clear_pulse();
        @(negedge clk);
        clr_req_i = 1'b1;
        @(negedge clk);
        clr_req_i = 1'b0;
        check(fifo_rst_n_o == 1'b0, "R9", "pulse cycle 1", int'(fifo_rst_n_o), 0);
        @(negedge clk);
        check(fifo_rst_n_o == 1'b0, "R9", "pulse cycle 2", int'(fifo_rst_n_o), 0);
        @(negedge clk);
        check(fifo_rst_n_o == 1'b1, "R9", "pulse end", int'(fifo_rst_n_o), 1);
        check(empty_n_o == 1'b0, "R9", "empty after clear", int'(empty_n_o), 0);
        check(full_n_o == 1'b1, "R9", "not full after clear", int'(full_n_o), 1);
        check(irq_o == 1'b0, "R9", "irq after clear", int'(irq_o), 0);
        exp_q.delete();
        model_cnt = 0;
    endtask

    // Monitor: compares read data with the scoreboard after each strobe.
    initial begin
        forever begin
            bit pend;
            @(posedge clk);
            pend = !rd_n_i;
            @(negedge clk);
            if (pend) begin
                if (exp_q.size() > 0) begin
                    logic [DATA_W-1:0] e;
                    e = exp_q.pop_front();
                    check(rd_data_o == e, rd_tag, "read word", int'(rd_data_o), int'(e));
                    last_rd = e;
                end else begin
                    check(rd_data_o == last_rd, "R8", "empty read holds data",
                          int'(rd_data_o), int'(last_rd));
                end
            end
        end
    end

    // Monitor: interrupt follows the full flag falling by one cycle (R6).
    initial begin
        forever begin
            @(negedge clk);
            if (expect_irq) begin
                check(irq_o == 1'b1, "R6", "irq one cycle after full", int'(irq_o), 1);
                expect_irq = 1'b0;
            end
            if (rst_n && prev_full_n && !full_n_o) begin
                check(irq_o == 1'b0, "R6", "irq not yet set", int'(irq_o), 0);
                expect_irq = 1'b1;
            end
            prev_full_n = full_n_o;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(full_n_o == 1'b1, "R1", "full_n_o", int'(full_n_o), 1);
        check(empty_n_o == 1'b0, "R1", "empty_n_o", int'(empty_n_o), 0);
        check(irq_o == 1'b0, "R1", "irq_o", int'(irq_o), 0);
        check(fifo_rst_n_o == 1'b1, "R1", "fifo_rst_n_o", int'(fifo_rst_n_o), 1);
        check(rd_data_o == '0, "R1", "rd_data_o", int'(rd_data_o), 0);

        clear_pulse();

        // Burst A: skew 4, fill past capacity (R3, R5, R6).
        skew_i = 4'd4;
        gates(1'b1, 1'b1);
        for (int i = 0; i < DEPTH + 8; i++) step(1'b1, DATA_W'(8'h10 + i), 1'b0);
        step(1'b0, '0, 1'b0);
        check(full_n_o == 1'b0, "R5", "full after burst", int'(full_n_o), 0);
        check(irq_o == 1'b1, "R6", "irq set", int'(irq_o), 1);
        gates(1'b0, 1'b0);
        for (int i = 0; i < 5; i++) step(1'b0, '0, 1'b0);
        check(irq_o == 1'b1, "R6", "irq sticky", int'(irq_o), 1);
        @(negedge clk);
        irq_ack_i = 1'b1;
        @(negedge clk);
        irq_ack_i = 1'b0;
        check(irq_o == 1'b0, "R6", "irq after ack", int'(irq_o), 0);

        rd_tag = "R3";
        for (int i = 0; i < DEPTH; i++) step(1'b0, '0, 1'b1);
        step(1'b0, '0, 1'b0);
        check(exp_q.size() == 0, "R3", "words left", exp_q.size(), 0);
        check(empty_n_o == 1'b0, "R7", "empty after drain", int'(empty_n_o), 0);
        // R8: reads on an empty store
        step(1'b0, '0, 1'b1);
        step(1'b0, '0, 1'b1);
        step(1'b0, '0, 1'b0);
        check(empty_n_o == 1'b0, "R8", "still empty", int'(empty_n_o), 0);

        // Burst B: skew 0, storage gate toggled mid-burst (R4, R8 pointer).
        skew_i = 4'd0;
        gates(1'b1, 1'b0);
        for (int i = 0; i < 3; i++) step(1'b1, DATA_W'(8'hA0 + i), 1'b0);
        check(empty_n_o == 1'b0, "R4", "nothing stored with gate off", int'(empty_n_o), 0);
        gates(1'b1, 1'b1);
        for (int i = 0; i < 5; i++) begin
            step(1'b1, DATA_W'(8'h40 + i), 1'b0);
            step(1'b0, 8'hEE, 1'b0);
        end
        gates(1'b1, 1'b0);
        for (int i = 0; i < 3; i++) step(1'b1, DATA_W'(8'hB0 + i), 1'b0);
        gates(1'b1, 1'b1);
        for (int i = 0; i < 2; i++) step(1'b1, DATA_W'(8'h60 + i), 1'b0);
        gates(1'b0, 1'b0);
        check(full_n_o == 1'b1, "R4", "not full", int'(full_n_o), 1);
        check(exp_q.size() == 7, "R4", "predicted words", exp_q.size(), 7);
        rd_tag = "R4";
        for (int i = 0; i < 7; i++) step(1'b0, '0, 1'b1);
        step(1'b0, '0, 1'b0);
        check(empty_n_o == 1'b0, "R7", "empty after burst B", int'(empty_n_o), 0);

        // Burst C: skew 7, fill, then clear withdraws the interrupt (R9).
        skew_i = 4'd7;
        clear_pulse();
        gates(1'b1, 1'b1);
        for (int i = 0; i < DEPTH + 12; i++) step(1'b1, DATA_W'(8'hC0 ^ i), 1'b0);
        step(1'b0, '0, 1'b0);
        check(full_n_o == 1'b0, "R5", "full after burst C", int'(full_n_o), 0);
        check(irq_o == 1'b1, "R6", "irq set burst C", int'(irq_o), 1);
        gates(1'b0, 1'b0);
        clear_pulse();
        step(1'b0, '0, 1'b1);
        step(1'b0, '0, 1'b0);
        check(rd_data_o == last_rd, "R8", "data after cleared read",
              int'(rd_data_o), int'(last_rd));

        summary();
        $finish;
    end
endmodule